// File: doc/BRIEF.md
# Type-0 Control Monitoring Slot Calculator

This block works out where a receiver must look for the type-0 common search-space control channel that belongs to a given synchronisation block. The offset O, the step M, the block index, the numerology mu, the cyclic-prefix type and the multiplexing pattern code are presented together with a one-cycle start strobe. The block returns the first monitoring slot inside the frame, the frame parity in which that slot lies, and the length of the monitoring window in slots. It also returns the frame geometry for the numerology: slots per frame and symbols per slot.

The step M is one of 1/2, 1 or 2. It is carried as a count of halves (1, 2 or 4), so the term floor(index·M) becomes exact integer arithmetic: (index·step_half) >> 1. The tables that give O and M are not part of this block.

The unit is a two-stage pipeline. The first stage forms the absolute slot count O·2^mu + floor(index·M). The second stage splits that count into a slot within the frame and a frame count. Every start yields exactly one done pulse. Results stay on the outputs until the next done pulse.

Top module: `t0mon_slot_calc`

## Requirements
- R1: When `mux_code` is 1 (multiplexing pattern 1), `win_slots` is 2.
- R2: When `mux_code` is any value other than 1 (2 and 3 are patterns 2 and 3), `win_slots` is 1, and `first_slot` and `frame_parity` are 0 whatever O, M and the index are.
- R3: For pattern 1, `first_slot` = (O·2^mu + floor(index·step_half/2)) mod slots_per_frame, where `cfg_step_half` is M in halves (1 means 1/2, 2 means 1, 4 means 2).
- R4: For pattern 1, `frame_parity` is bit 0 of floor((O·2^mu + floor(index·step_half/2)) / slots_per_frame). A value of 1 means an odd frame.
- R5: `slots_per_frame` equals 10·2^mu for mu 0 to 3 (10, 20, 40, 80).
- R6: `syms_per_slot` is 14 when `ext_cp` is 0 (normal prefix) and 12 when `ext_cp` is 1 (extended prefix).
- R7: A `num_mu` value above 3 is invalid. The result then has `err` = 1, and every other result output (`first_slot`, `frame_parity`, `win_slots`, `slots_per_frame`, `syms_per_slot`) is 0. A valid mu gives `err` = 0.
- R8: `done` is high for exactly one cycle, on the second rising edge after the edge that samples `start` high. Starts on consecutive cycles produce done pulses on consecutive cycles, in order. Results hold their value between done pulses.
- R9: While synchronous reset `rst` is high, and after it, `done`, `err` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe; the configuration inputs are sampled with it |
| cfg_offset | input | 4 | Offset O, in slots at numerology 0 |
| cfg_step_half | input | 3 | Step M as a count of halves (1, 2 or 4) |
| ssb_index | input | 6 | Synchronisation block index |
| num_mu | input | 3 | Numerology; 0 to 3 are valid |
| ext_cp | input | 1 | 1 selects extended cyclic prefix |
| mux_code | input | 2 | Multiplexing pattern code (1, 2 or 3) |
| done | output | 1 | One-cycle pulse marking fresh results |
| err | output | 1 | Numerology was invalid |
| first_slot | output | 7 | First monitoring slot within the frame |
| frame_parity | output | 1 | Parity of the frame that holds the first slot |
| win_slots | output | 2 | Number of consecutive monitoring slots |
| slots_per_frame | output | 7 | Slots per frame for the numerology |
| syms_per_slot | output | 4 | Symbols per slot |

## Verification
All results, and `done`, appear together on the second rising edge after the edge that sampled `start`. The bench drives each request on a falling edge and drops `start` on the next falling edge. It samples on the falling edge that follows, checking `done` and every result field there. It samples once more a cycle later to confirm that `done` has fallen and the results have held. For back-to-back starts the bench checks the two result sets on two consecutive falling edges, which tests the pipeline ordering under the same timing rule.

// File: rtl/t0mon_pkg.sv
package t0mon_pkg;

    localparam int OFS_W     = 4;
    localparam int IDX_W     = 6;
    localparam int STEP_W    = 3;
    localparam int MU_W      = 3;
    localparam int MU_MAX    = 3;
    localparam int SUBFRAMES = 10;
    localparam int SYM_NCP   = 14;
    localparam int SYM_ECP   = 12;

    localparam int OFS_SPAN  = OFS_W + MU_MAX;
    localparam int FRAC_SPAN = IDX_W + STEP_W - 1;
    localparam int SUM_W     = ((OFS_SPAN > FRAC_SPAN) ? OFS_SPAN : FRAC_SPAN) + 1;
    localparam int SLOT_W    = $clog2(SUBFRAMES << MU_MAX);
    localparam int SYM_W     = $clog2(SYM_NCP + 1);

    typedef enum logic [1:0] {
        MUX_NONE = 2'd0,
        MUX_P1   = 2'd1,
        MUX_P2   = 2'd2,
        MUX_P3   = 2'd3
    } mux_e;

    typedef struct packed {
        logic             vld;
        logic             pair_win;
        logic             ecp;
        logic [MU_W-1:0]  mu;
        logic [SUM_W-1:0] sum;
    } stage1_t;

    typedef struct packed {
        logic              err;
        logic [1:0]        win;
        logic [SLOT_W-1:0] first;
        logic              parity;
        logic [SLOT_W-1:0] spf;
        logic [SYM_W-1:0]  sps;
    } result_t;

    // floor(index * M) with M given in halves
    function automatic logic [SUM_W-1:0] frac_step(
        input logic [IDX_W-1:0]  idx,
        input logic [STEP_W-1:0] step_half
    );
        logic [IDX_W+STEP_W-1:0] prod;
        prod = IDX_W'(idx) * STEP_W'(step_half);
        prod = {{(IDX_W+STEP_W){1'b0}}, idx} * {{(IDX_W){1'b0}}, step_half};
        return SUM_W'(prod >> 1);
    endfunction

endpackage

// File: rtl/t0mon_frame_geom.sv
module t0mon_frame_geom
    import t0mon_pkg::*;
(
    input  logic [MU_W-1:0]   mu,
    input  logic              ecp,
    output logic              mu_ok,
    output logic [SLOT_W-1:0] spf,
    output logic [SYM_W-1:0]  sps
);

    always_comb begin
        mu_ok = (int'(mu) <= MU_MAX);
        spf   = '0;
        sps   = '0;
        if (mu_ok) begin
            spf = SLOT_W'(SUBFRAMES << mu);
            sps = ecp ? SYM_W'(SYM_ECP) : SYM_W'(SYM_NCP);
        end
    end

endmodule

// File: rtl/t0mon_sum_stage.sv
module t0mon_sum_stage
    import t0mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OFS_W-1:0]  offs,
    input  logic [STEP_W-1:0] step_half,
    input  logic [IDX_W-1:0]  idx,
    input  logic [MU_W-1:0]   mu,
    input  logic              ecp,
    input  logic [1:0]        mux,
    output stage1_t           s1
);

    logic [SUM_W-1:0] scaled_ofs;
    logic [SUM_W-1:0] abs_slot;

    always_comb begin
        scaled_ofs = SUM_W'({{(SUM_W-OFS_W){1'b0}}, offs} << mu);
        abs_slot   = scaled_ofs + frac_step(idx, step_half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= start;
            if (start) begin
                s1.pair_win <= (mux_e'(mux) == MUX_P1);
                s1.ecp      <= ecp;
                s1.mu       <= mu;
                s1.sum      <= abs_slot;
            end
        end
    end

endmodule

// File: rtl/t0mon_slot_div.sv
module t0mon_slot_div
    import t0mon_pkg::*;
(
    input  logic [SUM_W-1:0]  sum,
    input  logic [MU_W-1:0]   mu,
    output logic [SLOT_W-1:0] first,
    output logic              parity
);

    logic [SUM_W-1:0] scaled;
    logic [SUM_W-1:0] quo;
    logic [SUM_W-1:0] flen;
    logic [SUM_W-1:0] rem;

    // floor(s / (10*2^mu)) == floor(floor(s / 2^mu) / 10)
    always_comb begin
        scaled = sum >> mu;
        quo    = scaled / SUM_W'(SUBFRAMES);
        flen   = SUM_W'(SUBFRAMES << mu);
        rem    = sum - SUM_W'(quo * flen);
        first  = rem[SLOT_W-1:0];
        parity = quo[0];
    end

endmodule

// File: rtl/t0mon_slot_calc.sv
module t0mon_slot_calc
    import t0mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic [STEP_W-1:0] cfg_step_half,
    input  logic [IDX_W-1:0]  ssb_index,
    input  logic [MU_W-1:0]   num_mu,
    input  logic              ext_cp,
    input  logic [1:0]        mux_code,
    output logic              done,
    output logic              err,
    output logic [SLOT_W-1:0] first_slot,
    output logic              frame_parity,
    output logic [1:0]        win_slots,
    output logic [SLOT_W-1:0] slots_per_frame,
    output logic [SYM_W-1:0]  syms_per_slot
);

    stage1_t           s1;
    logic              mu_ok;
    logic [SLOT_W-1:0] geo_spf;
    logic [SYM_W-1:0]  geo_sps;
    logic [SLOT_W-1:0] div_first;
    logic              div_par;
    result_t           res;
    logic              done_q;

    t0mon_sum_stage u_sum (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .offs      (cfg_offset),
        .step_half (cfg_step_half),
        .idx       (ssb_index),
        .mu        (num_mu),
        .ecp       (ext_cp),
        .mux       (mux_code),
        .s1        (s1)
    );

    t0mon_frame_geom u_geom (
        .mu    (s1.mu),
        .ecp   (s1.ecp),
        .mu_ok (mu_ok),
        .spf   (geo_spf),
        .sps   (geo_sps)
    );

    t0mon_slot_div u_div (
        .sum    (s1.sum),
        .mu     (s1.mu),
        .first  (div_first),
        .parity (div_par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= s1.vld;
            if (s1.vld) begin
                if (!mu_ok) begin
                    res     <= '0;
                    res.err <= 1'b1;
                end else begin
                    res.err    <= 1'b0;
                    res.win    <= s1.pair_win ? 2'd2 : 2'd1;
                    res.first  <= s1.pair_win ? div_first : '0;
                    res.parity <= s1.pair_win ? div_par : 1'b0;
                    res.spf    <= geo_spf;
                    res.sps    <= geo_sps;
                end
            end
        end
    end

    assign done            = done_q;
    assign err             = res.err;
    assign first_slot      = res.first;
    assign frame_parity    = res.parity;
    assign win_slots       = res.win;
    assign slots_per_frame = res.spf;
    assign syms_per_slot   = res.sps;

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));

    assert_slot_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !err && win_slots == 2'd2) |-> (first_slot < slots_per_frame));

    assert_single_win_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !err && win_slots == 2'd1) |-> (first_slot == '0 && !frame_parity));

    assert_err_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (first_slot == '0 && !frame_parity && win_slots == 2'd0
                           && slots_per_frame == '0 && syms_per_slot == '0));

    assert_syms_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (syms_per_slot == SYM_W'(SYM_NCP) || syms_per_slot == SYM_W'(SYM_ECP)));

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(first_slot) && $stable(slots_per_frame) && $stable(err)));

endmodule

// File: tb/sim_t0mon_slot_calc.sv
module sim_t0mon_slot_calc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cfg_offset = '0;
    logic [2:0] cfg_step_half = '0;
    logic [5:0] ssb_index = '0;
    logic [2:0] num_mu = '0;
    logic       ext_cp = 1'b0;
    logic [1:0] mux_code = '0;
    logic       done, err, frame_parity;
    logic [6:0] first_slot, slots_per_frame;
    logic [1:0] win_slots;
    logic [3:0] syms_per_slot;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    t0mon_slot_calc u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_offset(cfg_offset), .cfg_step_half(cfg_step_half),
        .ssb_index(ssb_index), .num_mu(num_mu), .ext_cp(ext_cp),
        .mux_code(mux_code), .done(done), .err(err),
        .first_slot(first_slot), .frame_parity(frame_parity),
        .win_slots(win_slots), .slots_per_frame(slots_per_frame),
        .syms_per_slot(syms_per_slot)
    );

    // O, step_half, idx, mu, ecp, mux | first, parity, win, spf, sps, err
    localparam int NV = 10;
    localparam int VEC [NV][12] = '{
        '{ 0, 2,  0, 0, 0, 1,   0, 0, 2, 10, 14, 0},
        '{ 5, 1,  3, 1, 0, 1,  11, 0, 2, 20, 14, 0},
        '{15, 4,  7, 3, 1, 1,  54, 1, 2, 80, 12, 0},
        '{ 7, 4,  9, 0, 0, 1,   5, 0, 2, 10, 14, 0},
        '{ 2, 1,  5, 2, 0, 1,  10, 0, 2, 40, 14, 0},
        '{15, 2,  2, 0, 0, 1,   7, 1, 2, 10, 14, 0},
        '{ 5, 4,  3, 1, 1, 2,   0, 0, 1, 20, 12, 0},
        '{15, 4, 63, 3, 0, 3,   0, 0, 1, 80, 14, 0},
        '{15, 4, 63, 3, 0, 1,   6, 1, 2, 80, 14, 0},
        '{ 9, 2,  4, 5, 0, 1,   0, 0, 0,  0,  0, 1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int o, input int s, input int i, input int m, input int e, input int x);
        cfg_offset    = 4'(o);
        cfg_step_half = 3'(s);
        ssb_index     = 6'(i);
        num_mu        = 3'(m);
        ext_cp        = 1'(e);
        mux_code      = 2'(x);
    endtask

    task automatic check_res(input int v);
        chk("R8", "done", int'(done), 1);
        chk((VEC[v][5] == 1) ? "R3" : "R2", "first_slot", int'(first_slot), VEC[v][6]);
        chk((VEC[v][5] == 1) ? "R4" : "R2", "frame_parity", int'(frame_parity), VEC[v][7]);
        chk((VEC[v][5] == 1) ? "R1" : "R2", "win_slots", int'(win_slots), VEC[v][8]);
        chk("R5", "slots_per_frame", int'(slots_per_frame), VEC[v][9]);
        chk("R6", "syms_per_slot", int'(syms_per_slot), VEC[v][10]);
        chk("R7", "err", int'(err), VEC[v][11]);
    endtask

    task automatic run_vec(input int v);
        @(negedge clk);
        drive(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_res(v);
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "done", int'(done), 0);
        chk("R9", "err", int'(err), 0);
        chk("R9", "first_slot", int'(first_slot), 0);
        chk("R9", "win_slots", int'(win_slots), 0);
        chk("R9", "slots_per_frame", int'(slots_per_frame), 0);
        chk("R9", "syms_per_slot", int'(syms_per_slot), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "done after release", int'(done), 0);

        for (int v = 0; v < NV; v++) begin
            run_vec(v);
        end

        // R8: done falls after one cycle, results held
        run_vec(2);
        @(negedge clk);
        chk("R8", "done pulse width", int'(done), 0);
        chk("R8", "first_slot held", int'(first_slot), 54);
        chk("R8", "parity held", int'(frame_parity), 1);
        repeat (3) @(negedge clk);
        chk("R8", "spf held idle", int'(slots_per_frame), 80);

        // R7: mu = 4 is the first invalid value
        @(negedge clk);
        drive(3, 2, 1, 4, 0, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7", "err mu4", int'(err), 1);
        chk("R7", "spf mu4", int'(slots_per_frame), 0);
        chk("R7", "win mu4", int'(win_slots), 0);

        // R2: mux code 0 behaves as a single-slot window, slot fields ignored
        @(negedge clk);
        drive(9, 4, 20, 2, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R2", "win code0", int'(win_slots), 1);
        chk("R2", "first code0", int'(first_slot), 0);
        chk("R2", "parity code0", int'(frame_parity), 0);
        chk("R5", "spf mu2", int'(slots_per_frame), 40);

        // R8: back-to-back starts come out in order on consecutive cycles
        @(negedge clk);
        drive(VEC[1][0], VEC[1][1], VEC[1][2], VEC[1][3], VEC[1][4], VEC[1][5]);
        start = 1'b1;
        @(negedge clk);
        drive(VEC[8][0], VEC[8][1], VEC[8][2], VEC[8][3], VEC[8][4], VEC[8][5]);
        @(negedge clk);
        start = 1'b0;
        check_res(1);
        @(negedge clk);
        check_res(8);
        @(negedge clk);
        chk("R8", "done after burst", int'(done), 0);

        // R9: reset mid-stream clears results
        rst = 1'b1;
        @(negedge clk);
        chk("R9", "first_slot in reset", int'(first_slot), 0);
        chk("R9", "spf in reset", int'(slots_per_frame), 0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule